// File: doc/BRIEF.md
# Pseudo-SRAM Power-State Sequencer

This block steps one pseudo-SRAM die through its power states. After the supply comes good it holds the chip-select override and the active-low sleep pin high for a programmable settling time, then raises `ready` so the access controller may start cycles. On a host sleep request it drives the sleep pin low for a programmable suspend interval, after which the die is in deep power-down and its contents are gone. On a host wake request it releases the sleep pin and repeats the full settling interval before raising `ready` again.

Sleep requests are remembered while `bus_busy` reports an access in flight and take effect at the first idle cycle. Wake requests that arrive during the suspend interval are remembered and take effect once deep power-down has been reached. A sticky `data_lost` flag tells software that the die has lost its contents; only `lost_ack` clears it. A drop of `pwr_good` in any state restarts the power-up wait.

Top module: `psram_pwr_seq`

## Requirements
- R1: After reset `ready` is 0 and `sleep_n` and `cs_force` are 1; `ready` rises only after `pwr_good` has been sampled high on WAKE_CYCLES consecutive clock edges, the output changing in the cycle that follows the last of them.
- R2: While `ready` is 1, `sleep_n` is 1 and `cs_force` is 0.
- R3: A `sleep_req` sampled while `ready` is 1 and `bus_busy` is 0 makes `sleep_n` 0, `cs_force` 1 and `ready` 0 in the next cycle.
- R4: A `sleep_req` sampled while `bus_busy` is 1 is remembered; `ready` stays 1 until `bus_busy` is sampled 0, and the suspend starts from that edge.
- R5: `sleep_n` stays 0 for SUSPEND_CYCLES cycles of suspend, then deep power-down is entered and `data_lost` becomes 1 on that edge.
- R6: A `wake_req` pulse during the suspend does not shorten it; the wake sequence starts on the edge after deep power-down is reached.
- R7: A `wake_req` in deep power-down raises `sleep_n` in the next cycle with `cs_force` held at 1, and `ready` returns only after WAKE_CYCLES further cycles with `pwr_good` high.
- R8: `data_lost` stays 1 until `lost_ack` is sampled high; when deep power-down is entered on the same edge as an acknowledge, the flag is set.
- R9: `pwr_good` sampled low in any state returns the block to the power-up wait of R1 and drops any remembered request.
- R10: `wake_req` while `ready` is 1, and `sleep_req` during the power-up or wake wait, have no effect: the outputs follow as if the request had not occurred and it is not remembered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Supply at or above its minimum level |
| sleep_req | input | 1 | Host request to enter deep power-down |
| wake_req | input | 1 | Host request to leave deep power-down |
| bus_busy | input | 1 | An access to the die is in progress |
| lost_ack | input | 1 | Host acknowledge that clears `data_lost` |
| sleep_n | output | 1 | Active-low deep power-down pin of the die |
| cs_force | output | 1 | Forces the die's chip select inactive (high) |
| ready | output | 1 | Die may be accessed |
| data_lost | output | 1 | Sticky: contents were lost in deep power-down |

## Verification
Every output is a pure function of the registered state, so any wrong state or counter value appears at the ports on the next sample: a miscount shows as `ready` rising a cycle early or late, and a wrong state shows as a forbidden combination of `sleep_n`, `cs_force` and `ready`. The bench keeps a behavioural model using countdowns instead of the design's up-counter and compares all four outputs every cycle, so a divergence is caught within one clock of it arising. The scenarios place requests at the edges of each interval: during a busy bus, inside the suspend, on the deep power-down entry edge together with an acknowledge, and a supply drop in mid-sequence.

// File: rtl/psram_pwr_seq.sv
module psram_pwr_seq #(
  parameter int WAKE_CYCLES    = 40000,
  parameter int SUSPEND_CYCLES = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  input  logic sleep_req,
  input  logic wake_req,
  input  logic bus_busy,
  input  logic lost_ack,
  output logic sleep_n,
  output logic cs_force,
  output logic ready,
  output logic data_lost
);

  localparam int MAXC = (WAKE_CYCLES > SUSPEND_CYCLES) ? WAKE_CYCLES : SUSPEND_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [2:0] {S_PWRUP, S_RUN, S_SUSP, S_DPD, S_WAKE} state_t;

  state_t        st;
  logic [CW-1:0] cnt;
  logic          pend_sleep, pend_wake;

  wire settle_done  = (cnt == CW'(WAKE_CYCLES - 1));
  wire suspend_done = (cnt == CW'(SUSPEND_CYCLES - 1));
  wire go_sleep     = (sleep_req | pend_sleep) & ~bus_busy;

  assign ready    = (st == S_RUN);
  assign cs_force = (st != S_RUN);
  assign sleep_n  = (st != S_SUSP) && (st != S_DPD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_PWRUP;
      cnt        <= '0;
      pend_sleep <= 1'b0;
      pend_wake  <= 1'b0;
      data_lost  <= 1'b0;
    end else begin
      if (lost_ack) data_lost <= 1'b0;
      if (!pwr_good) begin
        st         <= S_PWRUP;
        cnt        <= '0;
        pend_sleep <= 1'b0;
        pend_wake  <= 1'b0;
      end else begin
        case (st)
          S_PWRUP, S_WAKE: begin
            if (settle_done) begin
              st  <= S_RUN;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_RUN: begin
            if (go_sleep) begin
              st         <= S_SUSP;
              cnt        <= '0;
              pend_sleep <= 1'b0;
            end else if (sleep_req) begin
              pend_sleep <= 1'b1;
            end
          end
          S_SUSP: begin
            if (wake_req) pend_wake <= 1'b1;
            if (suspend_done) begin
              st        <= S_DPD;
              cnt       <= '0;
              data_lost <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_DPD: begin
            if (wake_req | pend_wake) begin
              st        <= S_WAKE;
              cnt       <= '0;
              pend_wake <= 1'b0;
            end
          end
          default: begin
            st  <= S_PWRUP;
            cnt <= '0;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/psram_pwr_seq_chk.sv
module psram_pwr_seq_chk #(
  parameter int WAKE_CYCLES    = 40000,
  parameter int SUSPEND_CYCLES = 100
) (
  input logic clk,
  input logic rst_n,
  input logic pwr_good,
  input logic bus_busy,
  input logic lost_ack,
  input logic sleep_n,
  input logic cs_force,
  input logic ready,
  input logic data_lost
);

  logic [31:0] hold_cnt, low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cnt <= '0;
      low_cnt  <= '0;
    end else begin
      hold_cnt <= (sleep_n && cs_force && pwr_good && !ready) ? hold_cnt + 1 : '0;
      low_cnt  <= (!sleep_n) ? low_cnt + 1 : '0;
    end
  end

  AST_READY_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> hold_cnt >= 32'(WAKE_CYCLES)); // R1 R7

  AST_RUN_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (sleep_n && !cs_force)); // R2

  AST_LOW_FORCES_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_n |-> (cs_force && !ready)); // R3

  AST_SLEEP_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep_n) |-> (!$past(bus_busy) && $past(ready))); // R4

  AST_SUSPEND_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sleep_n) && $past(pwr_good)) |-> low_cnt >= 32'(SUSPEND_CYCLES)); // R6

  AST_LOST_IN_DPD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_lost) |-> !sleep_n); // R5

  AST_LOST_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_lost) |-> $past(lost_ack)); // R8

  AST_SUPPLY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> (!ready && sleep_n && cs_force)); // R9

endmodule

bind psram_pwr_seq psram_pwr_seq_chk #(
  .WAKE_CYCLES(WAKE_CYCLES),
  .SUSPEND_CYCLES(SUSPEND_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .bus_busy(bus_busy),
  .lost_ack(lost_ack), .sleep_n(sleep_n), .cs_force(cs_force),
  .ready(ready), .data_lost(data_lost)
);

// File: tb/psram_pwr_seq_test.sv
`timescale 1ns/1ps
module psram_pwr_seq_test;
  localparam int W = 20;
  localparam int S = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_good = 1'b0, sleep_req = 1'b0, wake_req = 1'b0, bus_busy = 1'b0, lost_ack = 1'b0;
  logic sleep_n, cs_force, ready, data_lost;

  int vectors = 0, miscompares = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  psram_pwr_seq #(.WAKE_CYCLES(W), .SUSPEND_CYCLES(S)) uut (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .sleep_req(sleep_req),
    .wake_req(wake_req), .bus_busy(bus_busy), .lost_ack(lost_ack),
    .sleep_n(sleep_n), .cs_force(cs_force), .ready(ready), .data_lost(data_lost)
  );

  // behavioural model: phases and countdowns
  localparam int PU = 0, RUN = 1, SUS = 2, DP = 3, WK = 4;
  int  ph, left;
  bit  m_lost, want_sleep, want_wake;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = PU; left = W; m_lost = 0; want_sleep = 0; want_wake = 0;
    end else begin
      bit nl;
      nl = m_lost && !lost_ack;
      if (!pwr_good) begin
        ph = PU; left = W; want_sleep = 0; want_wake = 0;
      end else if (ph == PU || ph == WK) begin
        left--;
        if (left == 0) ph = RUN;
      end else if (ph == RUN) begin
        if ((sleep_req || want_sleep) && !bus_busy) begin
          ph = SUS; left = S; want_sleep = 0;
        end else if (sleep_req) want_sleep = 1;
      end else if (ph == SUS) begin
        if (wake_req) want_wake = 1;
        left--;
        if (left == 0) begin ph = DP; nl = 1; end
      end else if (ph == DP) begin
        if (wake_req || want_wake) begin ph = WK; left = W; want_wake = 0; end
      end
      m_lost = nl;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [3:0] exp_v, act_v;
      exp_v = {ph == RUN, !(ph == SUS || ph == DP), ph != RUN, m_lost};
      act_v = {ready, sleep_n, cs_force, data_lost};
      vectors++;
      if (exp_v !== act_v) begin
        miscompares++;
        $display("FAIL %s cycle compare {ready,sleep_n,cs_force,data_lost} actual %b expected %b at %0t",
                 cur_req, act_v, exp_v, $time);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp_v);
    vectors++;
    if (act !== exp_v) begin
      miscompares++;
      $display("FAIL %s directed check actual %b expected %b at %0t", req, act, exp_v, $time);
    end
  endtask

  initial begin
    cyc(2);
    rst_n = 1'b1;
    cur_req = "R1";
    chk("R1", ready, 0); chk("R1", sleep_n, 1); chk("R1", cs_force, 1); chk("R1", data_lost, 0);
    cyc(4);
    pwr_good = 1'b1;
    cyc(10);
    cur_req = "R9";
    pwr_good = 1'b0; cyc(1); pwr_good = 1'b1;
    cur_req = "R1";
    cyc(W - 1);
    chk("R1", ready, 0);
    cyc(1);
    chk("R1", ready, 1);
    cur_req = "R2";
    chk("R2", cs_force, 0); chk("R2", sleep_n, 1);

    cur_req = "R10";
    wake_req = 1'b1; cyc(1); wake_req = 1'b0; cyc(3);
    chk("R10", ready, 1);

    cur_req = "R4";
    bus_busy = 1'b1; sleep_req = 1'b1; cyc(1); sleep_req = 1'b0;
    cyc(4);
    chk("R4", ready, 1);
    bus_busy = 1'b0; cyc(1);
    cur_req = "R3";
    chk("R3", sleep_n, 0); chk("R3", ready, 0); chk("R3", cs_force, 1);

    cur_req = "R6";
    cyc(1); wake_req = 1'b1; cyc(1); wake_req = 1'b0;
    cyc(S - 3);
    cur_req = "R5";
    chk("R5", data_lost, 0); chk("R5", sleep_n, 0);
    cyc(1);
    chk("R5", data_lost, 1);
    chk("R6", sleep_n, 0);
    cyc(1);
    cur_req = "R7";
    chk("R6", sleep_n, 1); chk("R7", cs_force, 1);
    cyc(W - 1);
    chk("R7", ready, 0);
    cyc(1);
    chk("R7", ready, 1);

    cur_req = "R8";
    cyc(3);
    chk("R8", data_lost, 1);
    lost_ack = 1'b1; cyc(1); lost_ack = 1'b0;
    chk("R8", data_lost, 0);

    sleep_req = 1'b1; cyc(1); sleep_req = 1'b0;
    lost_ack = 1'b1;
    cyc(S);
    chk("R8", data_lost, 1);
    cyc(1);
    chk("R8", data_lost, 0);
    lost_ack = 1'b0;
    cyc(3);

    cur_req = "R7";
    wake_req = 1'b1; cyc(1); wake_req = 1'b0;
    cur_req = "R10";
    cyc(3);
    sleep_req = 1'b1; cyc(1); sleep_req = 1'b0;
    cyc(W);
    chk("R10", ready, 1);
    cyc(5);
    chk("R10", ready, 1);

    cur_req = "R9";
    sleep_req = 1'b1; cyc(1); sleep_req = 1'b0;
    cyc(S + 2);
    pwr_good = 1'b0; cyc(1);
    chk("R9", sleep_n, 1); chk("R9", ready, 0);
    cyc(3);
    pwr_good = 1'b1;
    cyc(W);
    chk("R9", ready, 1);
    cyc(4);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule